// File: doc/BRIEF.md
# Manchester Line Encoder with Busy-Window Collision Guard

This block turns a framed serial bit stream into a Manchester-coded line signal and guards the transmission with a watchdog on a busy indication returned by the far end. Each bit occupies two equal half-bit periods. The bit rate is one of two values, 8 kHz or 10 kHz, derived from the system clock by a divider and chosen by a mode input. The line output can be inverted as a whole.

The upstream framer raises `frame_act` to start a message and keeps it high for as long as it has bits to send. The block takes one bit from `ser_data` at the start of each bit period and pulses `bit_stb` so that the framer can present the next bit. Bits are numbered from 1 at the start of the message. If the synchronized busy input is not seen high during any of bits 56 to 104, a collision is declared when bit 104 ends. The message stops at once. A sticky flag and an interrupt are raised, and optionally the transmitter-enable output is dropped. Only a pulse on the transmit-path reset clears this state.

Top module: `manch_guard_tx`

## Requirements
- R1: After reset the line rests at its idle level, and `bit_stb`, `col_flag` and `irq` are low while `tx_on` is high.
- R2: Each bit is two half-bit periods of equal length. Before inversion, a 1 is sent high then low and a 0 is sent low then high. The bit is taken from `ser_data` at the clock edge that starts it, and `bit_stb` is high during exactly the first clock cycle of every bit.
- R3: With `inv_sel` high, the line output is the complement of the uninverted signal, including the idle level. The idle level is low when `inv_sel` is low and high when it is high.
- R4: A bit lasts SYS_CLK_HZ/FAST_BPS clock cycles when `mode_sel` is 1 and SYS_CLK_HZ/SLOW_BPS cycles when it is 0. The mode is captured when a message starts, and changing `mode_sel` during the message has no effect on its timing.
- R5: A message starts on the first clock edge that sees `frame_act` high while the block is idle. A new bit follows each bit that ends with `frame_act` high. Transmission stops at the end of the first bit that ends with `frame_act` low, and the line then returns to idle.
- R6: Busy passes through a SYNC_STAGES flip-flop synchronizer. If the synchronized busy is not high during any of bits WIN_FIRST (56) to WIN_LAST (104), the end of bit 104 sets `col_flag` and ends the message: there is no further `bit_stb`, and the line goes idle on the next cycle. Busy seen only outside that window does not count. A message that ends before bit 104 never collides.
- R7: `col_flag` and `irq` stay high, and no new message starts whatever `frame_act` does, until a one-cycle pulse on `tx_rst` clears them at the next clock edge.
- R8: `tx_on` is low exactly while `col_flag` and `shut_en` are both high, and high otherwise.
- R9: A `tx_rst` pulse during a message aborts it. The line is idle from the next cycle, and no further `bit_stb` follows while `frame_act` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_rst | input | 1 | Synchronous transmit-path reset pulse; clears the collision |
| frame_act | input | 1 | High while the framer has message bits to send |
| ser_data | input | 1 | Next serial bit, taken at the start of each bit |
| mode_sel | input | 1 | Bit-rate select: 1 = fast rate, 0 = slow rate |
| inv_sel | input | 1 | Inverts the line output |
| busy | input | 1 | Asynchronous busy indication from the far end |
| shut_en | input | 1 | Lets a collision switch the transmitter off |
| line_out | output | 1 | Manchester-coded line signal |
| bit_stb | output | 1 | One-cycle strobe at the start of each transmitted bit |
| col_flag | output | 1 | Sticky transmit-collision flag |
| irq | output | 1 | Interrupt request, high while a collision is pending |
| tx_on | output | 1 | Transmitter enable control |

## Verification
A wrong half-bit counter or a wrongly latched rate shows up on the line within a single bit period, either as a mid-bit transition at the wrong cycle or as a `bit_stb` that arrives early or late. A wrong bit number or a lost busy-seen flag shows nothing until bit 104 ends. At that point the collision flag either fails to rise or rises on a message whose busy arrived in the window. Busy pulses placed in bits 55, 56 and 104 test the window edges. Because the collision is sticky, a wrongly set flag then blocks every later message until the transmit-path reset, so the error stays visible at the ports.

// File: rtl/mcw_pkg.sv
package mcw_pkg;

  typedef enum logic {
    ENC_IDLE = 1'b0,
    ENC_SEND = 1'b1
  } enc_state_e;

  // Clock cycles in one half-bit period for a given bit rate.
  function automatic int unsigned half_cycles(int unsigned clk_hz, int unsigned bps);
    return clk_hz / (2 * bps);
  endfunction

endpackage

// File: rtl/mcw_sync.sv
module mcw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = din;
    end else begin : g_many
      always_comb stg_d = {stg_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/mcw_halfdiv.sv
module mcw_halfdiv #(
  parameter int unsigned HALF_SLOW = 3125,
  parameter int unsigned HALF_FAST = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic fast,
  output logic phase,
  output logic bit_end
);

  localparam int unsigned HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int unsigned CW   = (HMAX < 2) ? 1 : $clog2(HMAX);
  localparam logic [CW-1:0] LIM_S = CW'(HALF_SLOW - 1);
  localparam logic [CW-1:0] LIM_F = CW'(HALF_FAST - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          fast_q, fast_d;
  logic [CW-1:0] lim;
  logic          half_end;

  generate
    if (HALF_SLOW == HALF_FAST) begin : g_single_rate
      always_comb lim = LIM_S;
    end else begin : g_dual_rate
      always_comb lim = fast_q ? LIM_F : LIM_S;
    end
  endgenerate

  always_comb begin
    half_end = run && (cnt_q == lim);
    cnt_d    = cnt_q;
    ph_d     = ph_q;
    fast_d   = fast_q;
    if (start) begin
      cnt_d  = '0;
      ph_d   = 1'b0;
      fast_d = fast;
    end else if (run) begin
      if (half_end) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      fast_q <= fast_d;
    end
  end

  assign phase   = ph_q;
  assign bit_end = half_end && ph_q;

endmodule

// File: rtl/mcw_watchdog.sv
module mcw_watchdog #(
  parameter int unsigned WIN_FIRST = 56,
  parameter int unsigned WIN_LAST  = 104
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic load,
  input  logic sending,
  input  logic bit_end,
  input  logic busy_s,
  output logic col_trig,
  output logic col_flag
);

  localparam int unsigned NW = $clog2(WIN_LAST + 2);
  localparam logic [NW-1:0] N_LO  = NW'(WIN_FIRST);
  localparam logic [NW-1:0] N_HI  = NW'(WIN_LAST);
  localparam logic [NW-1:0] N_ONE = NW'(1);
  localparam logic [NW-1:0] N_MAX = '1;

  logic [NW-1:0] num_q, num_d;
  logic          seen_q, seen_d;
  logic          col_q, col_d;
  logic          in_win;

  always_comb begin
    in_win   = sending && (num_q >= N_LO) && (num_q <= N_HI);
    col_trig = sending && bit_end && (num_q == N_HI) && !seen_q && !busy_s;

    num_d = num_q;
    if (start)                        num_d = N_ONE;
    else if (load && num_q != N_MAX)  num_d = num_q + 1'b1;

    seen_d = seen_q;
    if (start)                seen_d = 1'b0;
    else if (in_win && busy_s) seen_d = 1'b1;

    col_d = col_q;
    if (clr)           col_d = 1'b0;
    else if (col_trig) col_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      seen_q <= 1'b0;
      col_q  <= 1'b0;
    end else begin
      num_q  <= num_d;
      seen_q <= seen_d;
      col_q  <= col_d;
    end
  end

  assign col_flag = col_q;

endmodule

// File: rtl/mcw_encoder.sv
module mcw_encoder
  import mcw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic frame_act,
  input  logic ser_data,
  input  logic col_flag,
  input  logic col_trig,
  input  logic bit_end,
  input  logic phase,
  output logic sending,
  output logic start,
  output logic load,
  output logic bit_stb,
  output logic level
);

  enc_state_e st_q, st_d;
  logic       bit_q, bit_d;
  logic       stb_q, stb_d;
  logic       cont;

  always_comb begin
    sending = (st_q == ENC_SEND);
    start   = !sending && frame_act && !col_flag && !clr;
    cont    = sending && bit_end && frame_act && !col_trig && !clr;
    load    = start || cont;

    st_d = st_q;
    if (clr)                                            st_d = ENC_IDLE;
    else if (start)                                     st_d = ENC_SEND;
    else if (sending && bit_end && (!frame_act || col_trig)) st_d = ENC_IDLE;

    bit_d = load ? ser_data : bit_q;
    stb_d = load;
    level = sending && (bit_q ^ phase);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENC_IDLE;
      bit_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      stb_q <= stb_d;
    end
  end

  assign bit_stb = stb_q;

endmodule

// File: rtl/manch_guard_tx.sv
module manch_guard_tx #(
  parameter int unsigned SYS_CLK_HZ  = 50_000_000,
  parameter int unsigned SLOW_BPS    = 8_000,
  parameter int unsigned FAST_BPS    = 10_000,
  parameter int unsigned WIN_FIRST   = 56,
  parameter int unsigned WIN_LAST    = 104,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_rst,
  input  logic frame_act,
  input  logic ser_data,
  input  logic mode_sel,
  input  logic inv_sel,
  input  logic busy,
  input  logic shut_en,
  output logic line_out,
  output logic bit_stb,
  output logic col_flag,
  output logic irq,
  output logic tx_on
);

  localparam int unsigned HALF_SLOW = mcw_pkg::half_cycles(SYS_CLK_HZ, SLOW_BPS);
  localparam int unsigned HALF_FAST = mcw_pkg::half_cycles(SYS_CLK_HZ, FAST_BPS);

  logic [1:0] rs_q;
  logic       rst_n_s;
  logic       busy_s;
  logic       sending, start, load, level;
  logic       phase, bit_end;
  logic       col_trig;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  mcw_sync #(.STAGES(SYNC_STAGES)) u_bsync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (busy),
    .dout  (busy_s)
  );

  mcw_halfdiv #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .run     (sending),
    .fast    (mode_sel),
    .phase   (phase),
    .bit_end (bit_end)
  );

  mcw_watchdog #(.WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (tx_rst),
    .start    (start),
    .load     (load),
    .sending  (sending),
    .bit_end  (bit_end),
    .busy_s   (busy_s),
    .col_trig (col_trig),
    .col_flag (col_flag)
  );

  mcw_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (tx_rst),
    .frame_act (frame_act),
    .ser_data  (ser_data),
    .col_flag  (col_flag),
    .col_trig  (col_trig),
    .bit_end   (bit_end),
    .phase     (phase),
    .sending   (sending),
    .start     (start),
    .load      (load),
    .bit_stb   (bit_stb),
    .level     (level)
  );

  assign line_out = level ^ inv_sel;
  assign irq      = col_flag;
  assign tx_on    = !(col_flag && shut_en);

endmodule

// File: rtl/mcw_checker.sv
module mcw_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_rst,
  input logic shut_en,
  input logic inv_sel,
  input logic line_out,
  input logic bit_stb,
  input logic col_flag,
  input logic tx_on,
  input logic sending
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sending |-> (line_out == inv_sel)); // R3

  AST_STB_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> sending); // R2

  AST_NO_STB_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
    col_flag |-> !bit_stb); // R6

  AST_COL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (col_flag && !tx_rst) |=> col_flag); // R7

  AST_COL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> !col_flag); // R7

  AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (col_flag && shut_en) |-> !tx_on); // R8

endmodule

bind manch_guard_tx mcw_checker u_chk (.*);

// File: tb/manch_guard_tx_test.sv
module manch_guard_tx_test;

  localparam int unsigned CLK_HZ = 160_000;
  localparam int HS  = 10;    // half-bit cycles, slow (8 kHz)
  localparam int HF  = 8;     // half-bit cycles, fast (10 kHz)
  localparam int WLO = 56;
  localparam int WHI = 104;

  logic clk = 1'b0;
  logic rst_n, tx_rst, frame_act, ser_data, mode_sel, inv_sel, busy, shut_en;
  logic line_out, bit_stb, col_flag, irq, tx_on;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  manch_guard_tx #(.SYS_CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .frame_act(frame_act),
    .ser_data(ser_data), .mode_sel(mode_sel), .inv_sel(inv_sel), .busy(busy),
    .shut_en(shut_en), .line_out(line_out), .bit_stb(bit_stb),
    .col_flag(col_flag), .irq(irq), .tx_on(tx_on)
  );

  function automatic logic exp_line(logic b, int j, int h, logic inv);
    return ((j < h) ? b : ~b) ^ inv;
  endfunction

  function automatic bit exp_col(int nbits, int busy_at);
    return (nbits >= WHI) && !(busy_at >= WLO && busy_at <= WHI);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_msg(int nbits, bit fast, bit inv, bit shut, int busy_at);
    int  h    = fast ? HF : HS;
    bit  ec   = exp_col(nbits, busy_at);
    int  last = (ec && nbits > WHI) ? WHI : nbits;
    logic b, nb;
    int  bad;
    mode_sel = fast; inv_sel = inv; shut_en = shut;
    nb = logic'($urandom % 2);
    ser_data  = nb;
    frame_act = 1'b1;
    tick();
    for (int k = 1; k <= last; k++) begin
      b   = nb;
      bad = (bit_stb !== 1'b1) ? 1 : 0;
      nb  = logic'($urandom % 2);
      ser_data = nb;
      if (k == nbits) frame_act = 1'b0;
      if (k == 3) mode_sel = ~fast;       // R4: ignored mid-message
      for (int j = 0; j < 2 * h; j++) begin
        if (j > 0 && bit_stb) bad++;
        if (line_out !== exp_line(b, j, h, inv)) bad++;
        if (k == busy_at && j == 1) busy = 1'b1;
        if (k == busy_at && j == h) busy = 1'b0;
        tick();
      end
      chk(bad == 0, $sformatf("R2 R4 R3 bit %0d wave/timing errors", k), bad, 0);
    end
    busy = 1'b0;
    if (ec) begin
      chk(col_flag === 1'b1 && irq === 1'b1, "R6 collision flag/irq", int'(col_flag), 1);
      chk(bit_stb === 1'b0 && line_out === inv, "R6 stop after bit 104", int'(line_out), int'(inv));
      chk(tx_on === !shut, "R8 tx_on at collision", int'(tx_on), int'(!shut));
      bad = 0;
      for (int j = 0; j < 3 * h; j++) begin
        if (bit_stb || !col_flag || line_out !== inv) bad++;
        tick();
      end
      chk(bad == 0, "R7 held collision blocks data", bad, 0);
      frame_act = 1'b0;
      tx_rst = 1'b1;
      tick();
      tx_rst = 1'b0;
      chk(col_flag === 1'b0 && irq === 1'b0 && tx_on === 1'b1, "R7 R8 clear by tx_rst",
          int'(col_flag), 0);
    end else begin
      chk(bit_stb === 1'b0 && line_out === inv && col_flag === 1'b0,
          "R5 R6 end of message idle, no collision", int'(col_flag), 0);
    end
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; tx_rst = 1'b0; frame_act = 1'b0; ser_data = 1'b0;
    mode_sel = 1'b0; inv_sel = 1'b0; busy = 1'b0; shut_en = 1'b1;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk(line_out === 1'b0 && bit_stb === 1'b0, "R1 reset line/strobe", int'(line_out), 0);
    chk(col_flag === 1'b0 && irq === 1'b0 && tx_on === 1'b1, "R1 reset flags", int'(col_flag), 0);
    inv_sel = 1'b1; tick();
    chk(line_out === 1'b1, "R3 idle level inverted", int'(line_out), 1);
    inv_sel = 1'b0; tick();

    run_msg(24, 1'b0, 1'b0, 1'b0, 0);
    run_msg(24, 1'b1, 1'b1, 1'b0, 0);
    run_msg(120, 1'b0, 1'b0, 1'b1, 60);
    run_msg(120, 1'b1, 1'b0, 1'b1, 0);
    run_msg(120, 1'b0, 1'b1, 1'b0, 55);
    run_msg(120, 1'b1, 1'b0, 1'b0, 56);
    run_msg(110, 1'b1, 1'b1, 1'b1, 104);
    run_msg(104, 1'b0, 1'b0, 1'b1, 0);
    run_msg(100, 1'b1, 1'b0, 1'b0, 0);
    for (int r = 0; r < 4; r++) begin
      run_msg(20 + int'($urandom % 100), bit'($urandom % 2), bit'($urandom % 2),
              bit'($urandom % 2), int'($urandom % 120));
    end

    // R9: abort a message with tx_rst
    inv_sel = 1'b0; mode_sel = 1'b1; ser_data = 1'b1; frame_act = 1'b1;
    tick();
    chk(bit_stb === 1'b1, "R9 abort test message started", int'(bit_stb), 1);
    repeat (3) tick();
    frame_act = 1'b0; tx_rst = 1'b1;
    tick();
    tx_rst = 1'b0;
    chk(line_out === 1'b0 && bit_stb === 1'b0, "R9 line idle after abort", int'(line_out), 0);
    begin
      int bad = 0;
      for (int j = 0; j < 2 * HF; j++) begin
        if (bit_stb || line_out) bad++;
        tick();
      end
      chk(bad == 0, "R9 no activity after abort", bad, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule